// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when a memory controller must issue AUTO REFRESH commands to a 4,096-row SDRAM so that every row is refreshed inside the retention window. It counts clock cycles from a clock-frequency parameter and keeps a count of owed refreshes. It raises a request to the command arbiter whenever a refresh is owed and the previous refresh has had its full tRFC spacing. The arbiter answers with a one-cycle acknowledge each time it issues a refresh. The block drives no address, because the device picks refresh rows internally. Each acknowledge settles exactly one owed refresh.

Two policies are available. In distributed mode, one refresh falls due every window/rows interval. That is 15.625 µs on the 64 ms grade and 3.906 µs on the 16 ms grade. In burst mode, the whole row count falls due at once at the start of every window and is drained back-to-back at the tRFC rate. A grade input selects the 64 ms or 16 ms window.

If the arbiter falls behind in distributed mode, the owed count grows up to a postponement limit of 8. A due point that arrives at the limit raises a sticky underrun flag. While the device is in self refresh, the scheduler stops and owes nothing. On exit, it owes one refresh at once and restarts its interval timer.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, rf_req, sr_active and underrun are 0 and rf_owed is 0.
- R2: In distributed mode (burst_mode=0), rf_owed grows by one on every P-th clock edge counted from reset or from a timer restart. P is the window in µs times CLK_MHZ, divided by ROWS.
- R3: rf_req is 1 exactly when rf_owed is nonzero, the spacing gap has elapsed and sr_active is 0. An rf_ack sampled with rf_req high lowers rf_owed by one. An rf_ack sampled with rf_req low has no effect.
- R4: After an accepted acknowledge, rf_req stays low for TRFC_CYC-1 cycles, so refreshes are at least TRFC_CYC cycles apart.
- R5: In distributed mode, a due point that finds the owed count (after any same-cycle acknowledge) at or above POSTPONE_MAX leaves the count unchanged and sets underrun. Underrun then stays 1 until reset.
- R6: In burst mode, each window end (window µs times CLK_MHZ cycles) loads rf_owed with ROWS. If refreshes from the previous window are still owed at that point, underrun is set.
- R7: sr_enter while sr_active=0 sets sr_active on the next edge, clears rf_owed and freezes the timer. While sr_active=1, rf_req is 0 and rf_ack is ignored.
- R8: sr_exit while sr_active=1 clears sr_active and sets rf_owed to 1 on the next edge, and restarts the timer from zero.
- R9: ext_grade=1 selects the 16 ms window (EXT_WIN_US) for both intervals and bursts; ext_grade=0 selects the 64 ms window (STD_WIN_US).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 0 = distributed policy, 1 = burst policy |
| ext_grade | input | 1 | 0 = 64 ms window, 1 = 16 ms window |
| rf_ack | input | 1 | Arbiter issued one refresh this cycle |
| sr_enter | input | 1 | Device enters self refresh |
| sr_exit | input | 1 | Device leaves self refresh |
| rf_req | output | 1 | A refresh is owed and may be issued now |
| sr_active | output | 1 | Scheduler is paused for self refresh |
| underrun | output | 1 | Sticky flag: the refresh deadline was missed |
| rf_owed | output | OWED_W | Number of refreshes currently owed |

## Verification
Every state change happens on the first clock edge after the input that causes it. The one exception is the timer, whose due point lands on the P-th edge after reset or restart. The bench drives inputs on falling edges and compares every output on the next falling edge against a cycle model built from the requirements. A stimulus applied before edge k is therefore judged right after edge k. Directed checks count edges from reset release to place the interval, burst and postponement boundaries exactly: the 10th, 41st, 100th, 160th and 320th edge.

// File: rtl/sdram_rfs_pkg.sv
package sdram_rfs_pkg;

    typedef enum logic {
        POL_DIST  = 1'b0,
        POL_BURST = 1'b1
    } rfs_policy_e;

    function automatic int rfs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int rfs_cycles(input int win_us, input int clk_mhz);
        return win_us * clk_mhz;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hold,
    input  logic [TW-1:0] period,
    output logic          tick
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (!hold) begin
            if (st_q.cnt >= period - TW'(1)) begin
                tick     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: a frozen timer keeps its count
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> (st_q.cnt == $past(st_q.cnt)));

endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter
    import sdram_rfs_pkg::*;
#(
    parameter int CW    = 5,
    parameter int ROWS  = 16,
    parameter int LIMIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  rfs_policy_e   policy,
    input  logic          take,
    input  logic          clr,
    input  logic          set_one,
    output logic [CW-1:0] owed,
    output logic          underrun
);
    localparam logic [CW-1:0] ROWS_C  = CW'(ROWS);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] owed;
        logic          under;
    } owe_st_t;

    owe_st_t       st_d, st_q;
    logic [CW-1:0] base;
    logic          take_ok;

    always_comb begin
        take_ok = take && (st_q.owed != '0);
        base    = st_q.owed - CW'(take_ok);
        st_d    = st_q;
        if (clr) begin
            st_d.owed = '0;
        end else if (set_one) begin
            st_d.owed = CW'(1);
        end else if (tick && policy == POL_BURST) begin
            if (base != '0) st_d.under = 1'b1;
            st_d.owed = ROWS_C;
        end else if (tick) begin
            if (base >= LIMIT_C) begin
                st_d.under = 1'b1;
                st_d.owed  = base;
            end else begin
                st_d.owed  = base + CW'(1);
            end
        end else begin
            st_d.owed = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owed     = st_q.owed;
    assign underrun = st_q.under;

    // R3: a lone accepted acknowledge retires exactly one refresh
    a_r3_ack_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (take && owed != '0 && !tick && !clr && !set_one)
        |=> (owed == $past(owed) - CW'(1)));

    // R5: the underrun flag never clears outside reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    // R6: a burst window end reloads the full row count
    a_r6_burst_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && policy == POL_BURST && !clr && !set_one) |=> (owed == ROWS_C));

endmodule

// File: rtl/rfs_spacing.sv
module rfs_spacing #(
    parameter int TRFC_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    generate
        if (TRFC_CYC > 1) begin : g_gap
            localparam int GW = $clog2(TRFC_CYC);

            typedef struct packed {
                logic [GW-1:0] gap;
            } gap_st_t;

            gap_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (start)                st_d.gap = GW'(TRFC_CYC - 1);
                else if (st_q.gap != '0)  st_d.gap = st_q.gap - GW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign busy = (st_q.gap != '0);
        end else begin : g_nogap
            assign busy = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdram_rfs_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int ROWS         = 4096,
    parameter int STD_WIN_US   = 64000,
    parameter int EXT_WIN_US   = 16000,
    parameter int TRFC_CYC     = 7,
    parameter int POSTPONE_MAX = 8,
    localparam int OWED_W      = $clog2(rfs_max(ROWS, POSTPONE_MAX) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_mode,
    input  logic              ext_grade,
    input  logic              rf_ack,
    input  logic              sr_enter,
    input  logic              sr_exit,
    output logic              rf_req,
    output logic              sr_active,
    output logic              underrun,
    output logic [OWED_W-1:0] rf_owed
);
    localparam int STD_WIN_CYC = rfs_cycles(STD_WIN_US, CLK_MHZ);
    localparam int EXT_WIN_CYC = rfs_cycles(EXT_WIN_US, CLK_MHZ);
    localparam int STD_INT_CYC = STD_WIN_CYC / ROWS;
    localparam int EXT_INT_CYC = EXT_WIN_CYC / ROWS;
    localparam int TW          = $clog2(rfs_max(STD_WIN_CYC, EXT_WIN_CYC) + 1);

    localparam logic [TW-1:0] STD_WIN_P = TW'(STD_WIN_CYC);
    localparam logic [TW-1:0] EXT_WIN_P = TW'(EXT_WIN_CYC);
    localparam logic [TW-1:0] STD_INT_P = TW'(STD_INT_CYC);
    localparam logic [TW-1:0] EXT_INT_P = TW'(EXT_INT_CYC);

    typedef struct packed {
        logic sr_active;
    } top_st_t;

    top_st_t       st_d, st_q;
    rfs_policy_e   policy;
    logic [TW-1:0] period;
    logic          tick, gap_busy, enter_ok, exit_ok, take;

    always_comb begin
        policy   = burst_mode ? POL_BURST : POL_DIST;
        unique case ({burst_mode, ext_grade})
            2'b00:   period = STD_INT_P;
            2'b01:   period = EXT_INT_P;
            2'b10:   period = STD_WIN_P;
            default: period = EXT_WIN_P;
        endcase
        enter_ok = sr_enter && !st_q.sr_active;
        exit_ok  = sr_exit && st_q.sr_active;
        rf_req   = (rf_owed != '0) && !gap_busy && !st_q.sr_active;
        take     = rf_req && rf_ack && !enter_ok;
        st_d     = st_q;
        if (enter_ok)     st_d.sr_active = 1'b1;
        else if (exit_ok) st_d.sr_active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_active = st_q.sr_active;

    rfs_interval_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (enter_ok || exit_ok),
        .hold   (st_q.sr_active),
        .period (period),
        .tick   (tick)
    );

    rfs_owed_counter #(.CW(OWED_W), .ROWS(ROWS), .LIMIT(POSTPONE_MAX)) u_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .policy   (policy),
        .take     (take),
        .clr      (enter_ok),
        .set_one  (exit_ok),
        .owed     (rf_owed),
        .underrun (underrun)
    );

    rfs_spacing #(.TRFC_CYC(TRFC_CYC)) u_space (
        .clk   (clk),
        .rst_n (rst_n),
        .start (take),
        .busy  (gap_busy)
    );

    // R7: no request while the device refreshes itself
    a_r7_sr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !rf_req);

    // R7: entry clears the owed count and pauses
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_active && sr_enter) |=> (sr_active && rf_owed == '0));

    // R8: exit owes exactly one refresh
    a_r8_exit_one: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && sr_exit) |=> (!sr_active && rf_owed == OWED_W'(1)));

    generate
        if (TRFC_CYC > 1) begin : g_gap_chk
            // R4: an issued refresh is not followed by a request next cycle
            a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
                (rf_req && rf_ack) |=> !rf_req);
        end
    endgenerate

endmodule

// File: tb/sdram_refresh_sched_test.sv
module sdram_refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_MHZ = 1;
    localparam int T_ROWS = 16;
    localparam int T_STD = 640;
    localparam int T_EXT = 160;
    localparam int T_RFC = 3;
    localparam int T_LIM = 8;
    localparam int OW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b = 1'b0, g = 1'b0, ack = 1'b0, en = 1'b0, ex = 1'b0;
    logic rf_req, sr_active, underrun;
    logic [OW-1:0] rf_owed;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    int  m_cnt, m_owed, m_gap, m_base, m_per;
    bit  m_sr, m_und, m_req, m_take, m_enter, m_exit, m_tick;

    sdram_refresh_sched #(
        .CLK_MHZ(T_MHZ), .ROWS(T_ROWS), .STD_WIN_US(T_STD), .EXT_WIN_US(T_EXT),
        .TRFC_CYC(T_RFC), .POSTPONE_MAX(T_LIM)
    ) uut (
        .clk(clk), .rst_n(rst_n), .burst_mode(b), .ext_grade(g), .rf_ack(ack),
        .sr_enter(en), .sr_exit(ex), .rf_req(rf_req), .sr_active(sr_active),
        .underrun(underrun), .rf_owed(rf_owed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_of(input bit bb, input bit gg);
        int win;
        win = (gg ? T_EXT : T_STD) * T_MHZ;
        return bb ? win : win / T_ROWS;
    endfunction

    function automatic bit req_of(input int owed, input int gap, input bit sr);
        return (owed != 0) && (gap == 0) && !sr;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_owed = 0; m_gap = 0; m_sr = 0; m_und = 0;
        end else begin
            m_req   = req_of(m_owed, m_gap, m_sr);
            m_enter = en && !m_sr;
            m_exit  = ex && m_sr;
            m_take  = m_req && ack && !m_enter;
            m_per   = period_of(b, g);
            m_tick  = !m_enter && !m_exit && !m_sr && (m_cnt >= m_per - 1);
            if (m_enter || m_exit || m_tick) m_cnt = 0;
            else if (!m_sr) m_cnt = m_cnt + 1;
            m_base = m_owed - (m_take ? 1 : 0);
            if (m_enter) m_owed = 0;
            else if (m_exit) m_owed = 1;
            else if (m_tick && b) begin
                if (m_base != 0) m_und = 1;
                m_owed = T_ROWS;
            end else if (m_tick) begin
                if (m_base >= T_LIM) begin m_und = 1; m_owed = m_base; end
                else m_owed = m_base + 1;
            end else m_owed = m_base;
            if (m_take) m_gap = T_RFC - 1;
            else if (m_gap > 0) m_gap = m_gap - 1;
            if (m_enter) m_sr = 1;
            else if (m_exit) m_sr = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit bb, input bit gg, input bit a, input bit e, input bit x);
        @(negedge clk);
        check("R3 rf_req vs model", int'(rf_req), int'(req_of(m_owed, m_gap, m_sr)));
        check("R2 rf_owed vs model", int'(rf_owed), m_owed);
        check("R7 sr_active vs model", int'(sr_active), int'(m_sr));
        check("R5 underrun vs model", int'(underrun), int'(m_und));
        b = bb; g = gg; ack = a; en = e; ex = x;
    endtask

    task automatic do_reset(input bit bb, input bit gg);
        @(negedge clk);
        rst_n = 1'b0; b = bb; g = gg; ack = 0; en = 0; ex = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(b, g, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));

        // R1 reset state, R9 ext interval, R5 postponement limit
        do_reset(1'b0, 1'b1);
        #1;
        check("R1 req after reset", int'(rf_req), 0);
        check("R1 owed after reset", int'(rf_owed), 0);
        check("R1 sr_active after reset", int'(sr_active), 0);
        check("R1 underrun after reset", int'(underrun), 0);
        idle(10);
        check("R9 ext interval first due", int'(rf_owed), 1);
        idle(90);
        check("R5 owed capped at limit", int'(rf_owed), T_LIM);
        check("R5 underrun set", int'(underrun), 1);

        // R4 spacing after an accepted ack
        step(b, g, 1'b1, 1'b0, 1'b0);
        step(b, g, 1'b0, 1'b0, 1'b0);
        check("R4 req low after ack", int'(rf_req), 0);
        check("R3 owed after ack", int'(rf_owed), T_LIM - 1);

        // R7 self refresh entry, R8 exit
        step(b, g, 1'b0, 1'b1, 1'b0);
        step(b, g, 1'b0, 1'b0, 1'b0);
        check("R7 sr_active after entry", int'(sr_active), 1);
        check("R7 owed cleared on entry", int'(rf_owed), 0);
        for (int i = 0; i < 30; i++) step(b, g, 1'b1, 1'b0, 1'b0);
        check("R7 owed still zero in self refresh", int'(rf_owed), 0);
        check("R7 no req in self refresh", int'(rf_req), 0);
        step(b, g, 1'b0, 1'b0, 1'b1);
        step(b, g, 1'b0, 1'b0, 1'b0);
        check("R8 sr_active cleared", int'(sr_active), 0);
        check("R8 one refresh owed at exit", int'(rf_owed), 1);
        check("R8 request raised at exit", int'(rf_req), 1);

        // R2 standard grade interval
        do_reset(1'b0, 1'b0);
        idle(39);
        check("R2 nothing owed before interval", int'(rf_owed), 0);
        idle(2);
        check("R2 one owed after std interval", int'(rf_owed), 1);

        // R6 burst windows
        do_reset(1'b1, 1'b1);
        idle(160);
        check("R6 burst loads rows", int'(rf_owed), T_ROWS);
        check("R6 no underrun on first burst", int'(underrun), 0);
        idle(160);
        check("R6 underrun on unfinished burst", int'(underrun), 1);

        // random phases against the model
        for (int ph = 0; ph < 8; ph++) begin
            bit rb, rg;
            rb = ($urandom % 2) == 1;
            rg = ($urandom % 2) == 1;
            do_reset(rb, rg);
            for (int i = 0; i < 1500; i++) begin
                bit a, e, x;
                if (($urandom % 400) == 0) rb = ~rb;
                if (($urandom % 400) == 0) rg = ~rg;
                a = (($urandom % 4) != 0) ^ (ph % 2 == 1 && ($urandom % 3) == 0);
                e = ($urandom % 200) == 0;
                x = ($urandom % 40) == 0;
                step(rb, rg, a, e, x);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule